// File: doc/BRIEF.md
# Output-Enable Delay Tap Controller

This block holds the 9-bit tap setting that steers a programmable delay line on an output-enable path, and reports that setting. A compile-time mode picks one of three behaviours. In fixed mode the tap stays at a configured default. In stepped mode a step enable moves the tap up or down by one tap on each clock. In stepped-with-load mode a load strobe can also write an arbitrary tap value. The tap range wraps in both directions. A synchronous tap reset returns the setting to a configurable default, which may be nonzero.

The block also carries a small model of the tristate path. A registered output-enable bit is forced low as soon as the tristate reset is raised. The reset is released through a short synchronizer, so the path restarts cleanly on the clock. If a load and a step arrive on the same edge, the load is applied and a sticky violation flag is set.

Top module: `odly_tap_ctrl`

## Requirements
- R1: In stepped modes (MODE 1 or 2), while stepEn is high, tapCount changes by exactly one on each rising clk edge: up when stepUp=1, down when stepUp=0.
- R2: While stepEn and loadStb are both low, tapCount holds its value whatever stepUp is.
- R3: The tap count wraps: stepping up from 511 gives 0, and stepping down from 0 gives 511.
- R4: In MODE 2, loadStb high on a rising edge replaces tapCount with loadVal on that edge.
- R5: In MODE 2, if loadStb and stepEn are both high on an edge, the load wins and the step is dropped. protoErr goes high on that edge and stays high until tapRst.
- R6: tapRst is sampled on the rising edge and has priority over load and step. It sets tapCount to RESET_TAP and clears protoErr.
- R7: In MODE 0 (fixed), tapCount stays at RESET_TAP after reset. stepEn and loadStb have no effect, and protoErr stays low.
- R8: In MODE 1 (stepped, no load), loadStb is ignored and protoErr stays low.
- R9: triOut is 0 at once while triRst is high. After triRst falls, triOut stays 0 for two more rising edges and takes the registered value of triIn from the third edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for tap logic and tristate path |
| tapRst | input | 1 | Synchronous tap reset, active high |
| stepEn | input | 1 | Step enable |
| stepUp | input | 1 | Step direction: 1 up, 0 down |
| loadStb | input | 1 | Load strobe (MODE 2 only) |
| loadVal | input | 9 | Tap value written by a load |
| tapCount | output | 9 | Current tap setting |
| protoErr | output | 1 | Sticky flag for load and step on the same edge |
| triRst | input | 1 | Tristate path reset: asynchronous assert, synchronized release |
| triIn | input | 1 | Output-enable bit into the tristate path |
| triOut | output | 1 | Registered output-enable bit |

## Verification
The bench builds three copies of the block with RESET_TAP set to 37. The three copies use MODE 2, MODE 0 and MODE 1, and all of them are driven by the same stimulus. A nonzero default tap lets the bench tell a reset apart from a wrap to zero. Running the same load, step and collision patterns through the three modes shows, on the same edges, that loads are ignored in MODE 1, that everything is ignored in MODE 0, and that the sticky flag is set only in MODE 2.

// File: rtl/odly_pkg.sv
package odly_pkg;
  localparam int MODE_FIXED = 0;
  localparam int MODE_STEP  = 1;
  localparam int MODE_LOAD  = 2;

  typedef struct packed {
    logic doRst;
    logic doLoad;
    logic doInc;
    logic doDec;
    logic violation;
  } tap_cmd_t;
endpackage

// File: rtl/odly_ctrl.sv
module odly_ctrl
  import odly_pkg::*;
#(
  parameter int MODE = MODE_LOAD
) (
  input  logic     tapRst,
  input  logic     stepEn,
  input  logic     stepUp,
  input  logic     loadStb,
  output tap_cmd_t cmd
);
  localparam bit CAN_STEP = (MODE != MODE_FIXED);
  localparam bit CAN_LOAD = (MODE == MODE_LOAD);

  always_comb begin
    cmd = '0;
    if (tapRst) begin
      cmd.doRst = 1'b1;
    end else if (CAN_LOAD && loadStb) begin
      cmd.doLoad    = 1'b1;
      cmd.violation = stepEn;
    end else if (CAN_STEP && stepEn) begin
      cmd.doInc = stepUp;
      cmd.doDec = !stepUp;
    end
  end
endmodule

// File: rtl/odly_tap_dp.sv
module odly_tap_dp
  import odly_pkg::*;
#(
  parameter int TAP_W     = 9,
  parameter int RESET_TAP = 37
) (
  input  logic             clk,
  input  tap_cmd_t         cmd,
  input  logic [TAP_W-1:0] loadVal,
  output logic [TAP_W-1:0] tapQ,
  output logic             errQ
);
  localparam logic [TAP_W-1:0] DEF_TAP = TAP_W'(RESET_TAP);
  localparam logic [TAP_W-1:0] ONE     = TAP_W'(1);

  always_ff @(posedge clk) begin
    if (cmd.doRst) begin
      tapQ <= DEF_TAP;
      errQ <= 1'b0;
    end else begin
      if (cmd.doLoad)      tapQ <= loadVal;
      else if (cmd.doInc)  tapQ <= tapQ + ONE;
      else if (cmd.doDec)  tapQ <= tapQ - ONE;
      if (cmd.violation)   errQ <= 1'b1;
    end
  end
endmodule

// File: rtl/odly_tri_path.sv
module odly_tri_path #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic triRst,
  input  logic triIn,
  output logic triOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic relRst;

  always_ff @(posedge clk or posedge triRst) begin
    if (triRst) syncQ <= '1;
    else        syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b0};
  end

  assign relRst = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or posedge relRst) begin
    if (relRst) triOut <= 1'b0;
    else        triOut <= triIn;
  end
endmodule

// File: rtl/odly_tap_ctrl.sv
module odly_tap_ctrl
  import odly_pkg::*;
#(
  parameter int MODE        = MODE_LOAD,
  parameter int TAP_W       = 9,
  parameter int RESET_TAP   = 37,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             tapRst,
  input  logic             stepEn,
  input  logic             stepUp,
  input  logic             loadStb,
  input  logic [TAP_W-1:0] loadVal,
  output logic [TAP_W-1:0] tapCount,
  output logic             protoErr,
  input  logic             triRst,
  input  logic             triIn,
  output logic             triOut
);
  tap_cmd_t cmd;

  odly_ctrl #(.MODE(MODE)) u_ctrl (
    .tapRst(tapRst), .stepEn(stepEn), .stepUp(stepUp),
    .loadStb(loadStb), .cmd(cmd)
  );

  odly_tap_dp #(.TAP_W(TAP_W), .RESET_TAP(RESET_TAP)) u_dp (
    .clk(clk), .cmd(cmd), .loadVal(loadVal),
    .tapQ(tapCount), .errQ(protoErr)
  );

  odly_tri_path #(.SYNC_STAGES(SYNC_STAGES)) u_tri (
    .clk(clk), .triRst(triRst), .triIn(triIn), .triOut(triOut)
  );
endmodule

// File: rtl/odly_tap_chk.sv
module odly_tap_chk #(
  parameter int MODE      = 2,
  parameter int TAP_W     = 9,
  parameter int RESET_TAP = 37
) (
  input logic             clk,
  input logic             tapRst,
  input logic             stepEn,
  input logic             stepUp,
  input logic             loadStb,
  input logic [TAP_W-1:0] loadVal,
  input logic [TAP_W-1:0] tapCount,
  input logic             protoErr,
  input logic             triRst,
  input logic             triIn,
  input logic             triOut
);
  localparam logic [TAP_W-1:0] DEF_TAP = TAP_W'(RESET_TAP);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | tapRst;

  AST_RST_TAP: assert property (@(posedge clk) disable iff (!armed)
    tapRst |=> (tapCount == DEF_TAP && !protoErr)); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!armed || tapRst)
    (!stepEn && !loadStb) |=> $stable(tapCount)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!armed || tapRst)
    (MODE != 0 && stepEn && stepUp && !loadStb) |=> tapCount == TAP_W'($past(tapCount) + 1'b1)); // R1
  AST_STEP_DN: assert property (@(posedge clk) disable iff (!armed || tapRst)
    (MODE != 0 && stepEn && !stepUp && !loadStb) |=> tapCount == TAP_W'($past(tapCount) - 1'b1)); // R3
  AST_LOAD: assert property (@(posedge clk) disable iff (!armed || tapRst)
    (MODE == 2 && loadStb) |=> tapCount == $past(loadVal)); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!armed || tapRst)
    protoErr |=> protoErr); // R5
  AST_FIXED_TAP: assert property (@(posedge clk) disable iff (!armed)
    (MODE == 0) |-> (tapCount == DEF_TAP && !protoErr)); // R7
  AST_NOLOAD_ERR: assert property (@(posedge clk) disable iff (!armed)
    (MODE == 1) |-> !protoErr); // R8
  AST_TRI_ZERO: assert property (@(posedge clk)
    triRst |-> !triOut); // R9
endmodule

bind odly_tap_ctrl odly_tap_chk #(.MODE(MODE), .TAP_W(TAP_W), .RESET_TAP(RESET_TAP)) u_chk (.*);

// File: tb/odly_tap_ctrl_tb.sv
module odly_tap_ctrl_tb;
  localparam int TAP_W = 9;
  localparam int DEF = 37;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic tapRst = 1'b0, stepEn = 1'b0, stepUp = 1'b0, loadStb = 1'b0;
  logic [TAP_W-1:0] loadVal = '0;
  logic triRst = 1'b1, triIn = 1'b0;
  logic [TAP_W-1:0] tapL, tapF, tapV;
  logic errL, errF, errV, triL, triF, triV;

  int errors = 0;
  int checks = 0;

  odly_tap_ctrl #(.MODE(2), .RESET_TAP(DEF)) u_dut (
    .clk(clk), .tapRst(tapRst), .stepEn(stepEn), .stepUp(stepUp), .loadStb(loadStb),
    .loadVal(loadVal), .tapCount(tapL), .protoErr(errL), .triRst(triRst), .triIn(triIn), .triOut(triL));
  odly_tap_ctrl #(.MODE(0), .RESET_TAP(DEF)) u_fix (
    .clk(clk), .tapRst(tapRst), .stepEn(stepEn), .stepUp(stepUp), .loadStb(loadStb),
    .loadVal(loadVal), .tapCount(tapF), .protoErr(errF), .triRst(triRst), .triIn(triIn), .triOut(triF));
  odly_tap_ctrl #(.MODE(1), .RESET_TAP(DEF)) u_var (
    .clk(clk), .tapRst(tapRst), .stepEn(stepEn), .stepUp(stepUp), .loadStb(loadStb),
    .loadVal(loadVal), .tapCount(tapV), .protoErr(errV), .triRst(triRst), .triIn(triIn), .triOut(triV));

  // {rst, ce, inc, load, loadVal[9], expTap(MODE2)[9], expErr(MODE2), expTap(MODE1)[9]}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1,1'b0,1'b0,1'b0,9'd0,  9'd37, 1'b0,9'd37}, // R6 reset
    {1'b0,1'b1,1'b1,1'b0,9'd0,  9'd38, 1'b0,9'd38}, // R1 up
    {1'b0,1'b1,1'b1,1'b0,9'd0,  9'd39, 1'b0,9'd39}, // R1 up
    {1'b0,1'b1,1'b0,1'b0,9'd0,  9'd38, 1'b0,9'd38}, // R1 down
    {1'b0,1'b0,1'b1,1'b0,9'd510,9'd38, 1'b0,9'd38}, // R2 hold
    {1'b0,1'b0,1'b0,1'b1,9'd510,9'd510,1'b0,9'd38}, // R4 / R8 load
    {1'b0,1'b1,1'b1,1'b0,9'd0,  9'd511,1'b0,9'd39},
    {1'b0,1'b1,1'b1,1'b0,9'd0,  9'd0,  1'b0,9'd40}, // R3 511->0
    {1'b0,1'b1,1'b0,1'b0,9'd0,  9'd511,1'b0,9'd39}, // R3 0->511
    {1'b0,1'b0,1'b0,1'b1,9'd0,  9'd0,  1'b0,9'd39}, // R4 load zero
    {1'b0,1'b1,1'b0,1'b0,9'd5,  9'd511,1'b0,9'd38}, // R3 down wrap
    {1'b0,1'b1,1'b1,1'b1,9'd5,  9'd5,  1'b1,9'd39}, // R5 collision
    {1'b0,1'b0,1'b0,1'b0,9'd5,  9'd5,  1'b1,9'd39}, // R5 sticky
    {1'b1,1'b1,1'b1,1'b1,9'd5,  9'd37, 1'b0,9'd37}  // R6 priority
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      tapRst  = VEC[i][31];
      stepEn  = VEC[i][30];
      stepUp  = VEC[i][29];
      loadStb = VEC[i][28];
      loadVal = VEC[i][27:19];
      @(posedge clk); #1;
      chk("R1-R6 tap MODE2", int'(tapL), int'(VEC[i][18:10]));
      chk("R5 protoErr MODE2", int'(errL), int'(VEC[i][9]));
      chk("R8 tap MODE1", int'(tapV), int'(VEC[i][8:0]));
      chk("R8 protoErr MODE1", int'(errV), 0);
      chk("R7 tap MODE0", int'(tapF), DEF);
      chk("R7 protoErr MODE0", int'(errF), 0);
    end
    @(negedge clk);
    tapRst = 1'b0; stepEn = 1'b0; loadStb = 1'b0;

    // R9: held in reset, then released with triIn high
    triIn = 1'b1;
    chk("R9 triOut in reset", int'(triL), 0);
    triRst = 1'b0;
    @(posedge clk); #1; chk("R9 edge1 after release", int'(triL), 0);
    @(posedge clk); #1; chk("R9 edge2 after release", int'(triL), 0);
    @(posedge clk); #1; chk("R9 edge3 after release", int'(triL), 1);
    @(posedge clk); #1; chk("R9 follows triIn", int'(triV), 1);
    @(negedge clk); triIn = 1'b0;
    @(posedge clk); #1; chk("R9 follows triIn low", int'(triL), 0);
    @(negedge clk); triIn = 1'b1;
    @(posedge clk); #1; chk("R9 follows triIn high", int'(triL), 1);
    @(negedge clk); #3; triRst = 1'b1; #1;
    chk("R9 async assert", int'(triL), 0);
    chk("R9 async assert MODE0", int'(triF), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule